// File: doc/BRIEF.md
# Fused Multiply-Add Special Operand Resolver

This combinational block sits in front of the arithmetic datapath of a binary floating-point fused multiply-add unit that evaluates `z + x*y`. It sorts each of the three operands into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. From those classes it decides whether the final result is already fixed, so that the mantissa multiplier, aligner, adder and rounder can be bypassed.

Two controls flip the signs of the product and the addend independently. This gives the four multiply-add flavours: plain, negated product, negated addend and both negated. A third control reports that the rounding mode is toward minus infinity. That control only matters when exact zeros of opposite sign cancel.

When no special case applies, the block leaves the bypass flag low. It still hands the effective product and addend signs to the datapath. Exponent and fraction widths are parameters. The defaults give the 32-bit single-precision format: sign at bit 31, exponent in bits 30:23, fraction in bits 22:0, and the quiet marker at fraction bit 22.

Top module: `fma_special_resolve`

## Requirements
- R1: `prod_sign` equals `x_op[31] ^ y_op[31] ^ negate_prod`, and `addend_sign` equals `z_op[31] ^ negate_addend`, for every input combination.
- R2: When any operand is a signalling NaN (exponent all ones, fraction nonzero, bit 22 clear), the first such operand in the order z, x, y is returned with bit 22 set. `bypass_valid` and `invalid_op` are both high.
- R3: When no operand is a signalling NaN but some operand is a quiet NaN (exponent all ones, bit 22 set), the first quiet NaN in the order z, x, y is returned bit for bit. `bypass_valid` is high and `invalid_op` is low.
- R4: Without NaN operands, an infinite multiplicand times a zero multiplicand gives `invalid_op` high and the result 0x7FC00000, whatever z is.
- R5: Without NaN operands, an infinite product added to an infinite z whose effective addend sign differs from `prod_sign` gives `invalid_op` high and the result 0x7FC00000.
- R6: In every other case where the product is infinite, the result is an infinity carrying `prod_sign`, with `invalid_op` low.
- R7: A finite product (neither multiplicand infinite or NaN) added to an infinite z gives an infinity carrying `addend_sign`.
- R8: A zero product added to a nonzero finite z gives z's magnitude carrying `addend_sign`.
- R9: A zero product added to a zero z with `prod_sign == addend_sign` gives a zero carrying that sign.
- R10: A zero product added to a zero z with opposite effective signs gives +0 (0x00000000) when `round_down` is low, and -0 (0x80000000) when it is high.
- R11: When no special case applies, `bypass_valid` and `invalid_op` are low and `bypass_result` is 0x00000000.
- R12: Subnormal operands count as nonzero finite values. A subnormal z with a zero product is returned with its magnitude intact. A product of subnormal or normal multiplicands with a finite nonzero z is not bypassed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| z_op | input | 32 | Addend operand |
| x_op | input | 32 | First multiplicand |
| y_op | input | 32 | Second multiplicand |
| negate_prod | input | 1 | Invert the product sign |
| negate_addend | input | 1 | Invert the addend sign |
| round_down | input | 1 | Rounding mode is toward minus infinity |
| bypass_valid | output | 1 | A special result replaces the datapath result |
| bypass_result | output | 32 | The special result (zero when not bypassing) |
| invalid_op | output | 1 | Invalid-operation exception |
| prod_sign | output | 1 | Effective sign of x*y |
| addend_sign | output | 1 | Effective sign of z |

## Verification
The bench builds the resolver with its default parameters: an 8-bit exponent and a 23-bit fraction. With these values, every operand can be written as a familiar 32-bit pattern, and the reference model can state the default NaN and the quiet bit as fixed constants. Within that width, the vectors cover the following:
- each NaN priority pairing;
- both negate controls against every infinity and zero rule;
- both rounding settings on cancelling zeros;
- subnormal operands on both the multiplicand and addend sides.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   typedef enum logic [2:0] {
      CLS_ZERO = 3'd0,
      CLS_SUB  = 3'd1,
      CLS_NORM = 3'd2,
      CLS_INF  = 3'd3,
      CLS_QNAN = 3'd4,
      CLS_SNAN = 3'd5
   } opclass_e;

   localparam int unsigned NUM_OPS = 3;  // index 0 = z, 1 = x, 2 = y
endpackage

// File: rtl/fsr_classify.sv
module fsr_classify
   import fsr_pkg::*;
#(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 23,
   localparam int unsigned W = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0] op,
   output opclass_e     cls
);
   logic [EXP_W-1:0] expf;
   logic [MAN_W-1:0] frac;
   logic             exp_max;
   logic             exp_min;
   logic             frac_nz;

   assign expf    = op[W-2 -: EXP_W];
   assign frac    = op[MAN_W-1:0];
   assign exp_max = &expf;
   assign exp_min = ~|expf;
   assign frac_nz = |frac;

   always_comb begin
      if (exp_max) begin
         if (!frac_nz)              cls = CLS_INF;
         else if (frac[MAN_W-1])    cls = CLS_QNAN;
         else                       cls = CLS_SNAN;
      end else if (exp_min) begin
         cls = frac_nz ? CLS_SUB : CLS_ZERO;
      end else begin
         cls = CLS_NORM;
      end
   end
endmodule

// File: rtl/fsr_nan_pick.sv
module fsr_nan_pick
   import fsr_pkg::*;
#(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 23,
   localparam int unsigned W = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0] ops [NUM_OPS],
   input  opclass_e     cls [NUM_OPS],
   output logic         nan_hit,
   output logic [W-1:0] nan_result,
   output logic         nan_invalid
);
   localparam logic [W-1:0] QUIET_MASK = W'(1) << (MAN_W - 1);

   // Walk from the lowest priority up so that the earliest operand wins;
   // the signalling pass runs last so it overrides any quiet pick.
   always_comb begin
      nan_hit     = 1'b0;
      nan_result  = '0;
      nan_invalid = 1'b0;
      for (int i = NUM_OPS - 1; i >= 0; i--) begin
         if (cls[i] == CLS_QNAN) begin
            nan_hit    = 1'b1;
            nan_result = ops[i];
         end
      end
      for (int i = NUM_OPS - 1; i >= 0; i--) begin
         if (cls[i] == CLS_SNAN) begin
            nan_hit     = 1'b1;
            nan_invalid = 1'b1;
            nan_result  = ops[i] | QUIET_MASK;
         end
      end
   end
endmodule

// File: rtl/fsr_infzero.sv
module fsr_infzero
   import fsr_pkg::*;
#(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 23,
   localparam int unsigned W = 1 + EXP_W + MAN_W
) (
   input  opclass_e     z_cls,
   input  opclass_e     x_cls,
   input  opclass_e     y_cls,
   input  logic [W-2:0] z_mag,
   input  logic         p_sign,
   input  logic         a_sign,
   input  logic         rnd_down,
   output logic         hit,
   output logic [W-1:0] result,
   output logic         invalid
);
   localparam logic [W-1:0] DEF_NAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   logic p_inf, p_zero, z_inf, z_zero;

   assign p_inf  = (x_cls == CLS_INF)  || (y_cls == CLS_INF);
   assign p_zero = (x_cls == CLS_ZERO) || (y_cls == CLS_ZERO);
   assign z_inf  = (z_cls == CLS_INF);
   assign z_zero = (z_cls == CLS_ZERO);

   function automatic logic [W-1:0] inf_of(input logic s);
      return {s, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
   endfunction

   function automatic logic [W-1:0] zero_of(input logic s);
      return {s, {(W-1){1'b0}}};
   endfunction

   always_comb begin
      hit     = 1'b1;
      invalid = 1'b0;
      result  = '0;
      if (p_inf && p_zero) begin
         invalid = 1'b1;
         result  = DEF_NAN;
      end else if (p_inf) begin
         if (z_inf && (a_sign != p_sign)) begin
            invalid = 1'b1;
            result  = DEF_NAN;
         end else begin
            result = inf_of(p_sign);
         end
      end else if (z_inf) begin
         result = inf_of(a_sign);
      end else if (p_zero) begin
         if (!z_zero)               result = {a_sign, z_mag};
         else if (a_sign == p_sign) result = zero_of(a_sign);
         else                       result = zero_of(rnd_down);
      end else begin
         hit = 1'b0;
      end
   end
endmodule

// File: rtl/fma_special_resolve.sv
module fma_special_resolve
   import fsr_pkg::*;
#(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 23,
   localparam int unsigned W = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0] z_op,
   input  logic [W-1:0] x_op,
   input  logic [W-1:0] y_op,
   input  logic         negate_prod,
   input  logic         negate_addend,
   input  logic         round_down,
   output logic         bypass_valid,
   output logic [W-1:0] bypass_result,
   output logic         invalid_op,
   output logic         prod_sign,
   output logic         addend_sign
);
   localparam logic [W-1:0] DEF_NAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   generate
      if (EXP_W < 2 || EXP_W > 15) begin : g_bad_exp
         $error("fma_special_resolve: EXP_W out of range");
      end
      if (MAN_W < 2) begin : g_bad_man
         $error("fma_special_resolve: MAN_W must leave room for a quiet bit and payload");
      end
   endgenerate

   logic [W-1:0] ops [NUM_OPS];
   opclass_e     cls [NUM_OPS];

   assign ops[0] = z_op;
   assign ops[1] = x_op;
   assign ops[2] = y_op;

   generate
      for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
         fsr_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .op  (ops[g]),
            .cls (cls[g])
         );
      end
   endgenerate

   assign prod_sign   = x_op[W-1] ^ y_op[W-1] ^ negate_prod;
   assign addend_sign = z_op[W-1] ^ negate_addend;

   logic         nan_hit, nan_inv;
   logic [W-1:0] nan_res;

   fsr_nan_pick #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_nan (
      .ops         (ops),
      .cls         (cls),
      .nan_hit     (nan_hit),
      .nan_result  (nan_res),
      .nan_invalid (nan_inv)
   );

   logic         iz_hit, iz_inv;
   logic [W-1:0] iz_res;

   fsr_infzero #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_iz (
      .z_cls    (cls[0]),
      .x_cls    (cls[1]),
      .y_cls    (cls[2]),
      .z_mag    (z_op[W-2:0]),
      .p_sign   (prod_sign),
      .a_sign   (addend_sign),
      .rnd_down (round_down),
      .hit      (iz_hit),
      .result   (iz_res),
      .invalid  (iz_inv)
   );

   always_comb begin
      if (nan_hit) begin
         bypass_valid  = 1'b1;
         bypass_result = nan_res;
         invalid_op    = nan_inv;
      end else begin
         bypass_valid  = iz_hit;
         bypass_result = iz_res;
         invalid_op    = iz_inv;
      end
   end

   // Checks against the class decode and the final mux outputs
   logic any_snan, any_qnan, any_inf_mul;
   always_comb begin
      any_snan = 1'b0;
      any_qnan = 1'b0;
      for (int i = 0; i < NUM_OPS; i++) begin
         if (cls[i] == CLS_SNAN) any_snan = 1'b1;
         if (cls[i] == CLS_QNAN) any_qnan = 1'b1;
      end
      any_inf_mul = (cls[1] == CLS_INF) || (cls[2] == CLS_INF);
   end

   always_comb begin
      if (any_snan)
         assert_snan_flags_R2: assert (invalid_op && bypass_valid)
            else $error("signalling NaN without invalid flag");
      if (!any_snan && any_qnan)
         assert_qnan_quiet_R3: assert (!invalid_op && bypass_valid)
            else $error("quiet NaN raised a flag or was not bypassed");
      if (invalid_op && !any_snan)
         assert_default_nan_R4: assert (bypass_result == DEF_NAN)
            else $error("invalid result is not the default NaN");
      if (!any_snan && !any_qnan && any_inf_mul && !invalid_op)
         assert_inf_sign_R6: assert (bypass_valid &&
                                     bypass_result == {prod_sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}})
            else $error("infinite product did not yield signed infinity");
      if (!bypass_valid)
         assert_idle_R11: assert (!invalid_op && bypass_result == '0)
            else $error("idle outputs not quiet");
   end
endmodule

// File: tb/fma_special_resolve_test.sv
module fma_special_resolve_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;  // 50 MHz

   logic [31:0] z_op, x_op, y_op;
   logic        negate_prod, negate_addend, round_down;
   logic        bypass_valid, invalid_op, prod_sign, addend_sign;
   logic [31:0] bypass_result;

   fma_special_resolve uut (
      .z_op          (z_op),
      .x_op          (x_op),
      .y_op          (y_op),
      .negate_prod   (negate_prod),
      .negate_addend (negate_addend),
      .round_down    (round_down),
      .bypass_valid  (bypass_valid),
      .bypass_result (bypass_result),
      .invalid_op    (invalid_op),
      .prod_sign     (prod_sign),
      .addend_sign   (addend_sign)
   );

   typedef struct packed {
      logic        v;
      logic [31:0] r;
      logic        i;
      logic        ps;
      logic        as;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    checks = 0;
   int    errors = 0;
   bit    done = 0;

   function automatic bit f_nan(input logic [31:0] v);  return (&v[30:23]) && (|v[22:0]); endfunction
   function automatic bit f_snan(input logic [31:0] v); return f_nan(v) && !v[22]; endfunction
   function automatic bit f_qnan(input logic [31:0] v); return f_nan(v) && v[22]; endfunction
   function automatic bit f_inf(input logic [31:0] v);  return (&v[30:23]) && !(|v[22:0]); endfunction
   function automatic bit f_zero(input logic [31:0] v); return v[30:0] == 31'd0; endfunction

   // Reference model written from the requirement list
   function automatic exp_t model(input logic [31:0] z, x, y, input logic np, na, rd);
      exp_t e;
      logic pinf, pzero;
      e = '0;
      e.ps = x[31] ^ y[31] ^ np;          // R1
      e.as = z[31] ^ na;
      pinf  = f_inf(x) || f_inf(y);
      pzero = f_zero(x) || f_zero(y);
      e.v = 1'b1;
      if (f_snan(z))      begin e.r = z | 32'h0040_0000; e.i = 1; end     // R2
      else if (f_snan(x)) begin e.r = x | 32'h0040_0000; e.i = 1; end
      else if (f_snan(y)) begin e.r = y | 32'h0040_0000; e.i = 1; end
      else if (f_qnan(z)) e.r = z;                                         // R3
      else if (f_qnan(x)) e.r = x;
      else if (f_qnan(y)) e.r = y;
      else if (pinf && pzero) begin e.r = 32'h7FC0_0000; e.i = 1; end      // R4
      else if (pinf && f_inf(z) && e.as != e.ps) begin e.r = 32'h7FC0_0000; e.i = 1; end // R5
      else if (pinf) e.r = {e.ps, 8'hFF, 23'd0};                           // R6
      else if (f_inf(z)) e.r = {e.as, 8'hFF, 23'd0};                       // R7
      else if (pzero && !f_zero(z)) e.r = {e.as, z[30:0]};                 // R8, R12
      else if (pzero && e.as == e.ps) e.r = {e.as, 31'd0};                 // R9
      else if (pzero) e.r = {rd, 31'd0};                                   // R10
      else e.v = 1'b0;                                                     // R11
      return e;
   endfunction

   task automatic drive(input logic [31:0] z, x, y, input logic np, na, rd, input string tag);
      @(posedge clk);
      #2;
      z_op = z; x_op = x; y_op = y;
      negate_prod = np; negate_addend = na; round_down = rd;
      exp_q.push_back(model(z, x, y, np, na, rd));
      tag_q.push_back(tag);
   endtask

   // Monitor: compares at the falling edge, away from input changes
   always @(negedge clk) begin
      if (rst_n && exp_q.size() > 0) begin
         exp_t  e;
         string t;
         exp_t  a;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = '{v: bypass_valid, r: bypass_result, i: invalid_op, ps: prod_sign, as: addend_sign};
         checks++;
         if (a != e) begin
            errors++;
            $display("FAIL %s: actual v=%0b r=%08h inv=%0b ps=%0b as=%0b expected v=%0b r=%08h inv=%0b ps=%0b as=%0b",
                     t, a.v, a.r, a.i, a.ps, a.as, e.v, e.r, e.i, e.ps, e.as);
         end
      end
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      z_op = '0; x_op = '0; y_op = '0;
      negate_prod = 0; negate_addend = 0; round_down = 0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Reset-state pattern: all zeros -> equal-sign zero sum
      drive(32'h0, 32'h0, 32'h0, 0, 0, 0, "R9 reset zeros");
      // R11 / R12 ordinary operands
      drive(32'h3F80_0000, 32'h4000_0000, 32'h4040_0000, 0, 0, 0, "R11 normal no bypass");
      drive(32'h3F80_0000, 32'h0000_0001, 32'h0000_0002, 0, 0, 0, "R12 subnormal product no bypass");
      // R1 sign combinations
      drive(32'hBF80_0000, 32'hC000_0000, 32'h4040_0000, 1, 0, 0, "R1 negate product");
      drive(32'hBF80_0000, 32'hC000_0000, 32'hC040_0000, 0, 1, 0, "R1 negate addend");
      // R2 signalling NaN priority and quieting
      drive(32'h7F80_0001, 32'h7FA0_0000, 32'h3F80_0000, 0, 0, 0, "R2 snan z over x");
      drive(32'h3F80_0000, 32'h7FA0_0000, 32'hFF80_0002, 0, 0, 0, "R2 snan x over y");
      drive(32'h7FC1_2345, 32'h3F80_0000, 32'hFF80_0005, 0, 0, 0, "R2 snan y over qnan z");
      // R3 quiet NaN priority
      drive(32'h3F80_0000, 32'h7FC0_0011, 32'hFFC1_2345, 0, 0, 0, "R3 qnan x over y");
      drive(32'h3F80_0000, 32'h4000_0000, 32'hFFC1_2345, 1, 1, 0, "R3 qnan y unchanged");
      drive(32'h7FC0_0022, 32'h7F80_0000, 32'h0000_0000, 0, 0, 0, "R3 qnan z beats inf*0");
      // R4 infinity times zero
      drive(32'h3F80_0000, 32'h7F80_0000, 32'h0000_0000, 0, 0, 0, "R4 inf*0");
      drive(32'hFF80_0000, 32'h8000_0000, 32'hFF80_0000, 0, 0, 0, "R4 0*inf with inf z");
      // R5 / R6 infinite product
      drive(32'hFF80_0000, 32'h7F80_0000, 32'h4000_0000, 0, 0, 0, "R5 inf - inf");
      drive(32'hFF80_0000, 32'h7F80_0000, 32'h4000_0000, 0, 1, 0, "R6 inf + negated -inf");
      drive(32'h40A0_0000, 32'h7F80_0000, 32'hC040_0000, 0, 0, 0, "R6 -inf product");
      drive(32'h40A0_0000, 32'h7F80_0000, 32'hC040_0000, 1, 0, 0, "R6 negated product +inf");
      drive(32'h7F80_0000, 32'hFF80_0000, 32'hFF80_0000, 0, 0, 0, "R6 inf*inf + inf");
      // R7 finite product, infinite z
      drive(32'hFF80_0000, 32'h4000_0000, 32'h4040_0000, 0, 0, 0, "R7 -inf z");
      drive(32'hFF80_0000, 32'h4000_0000, 32'h4040_0000, 0, 1, 0, "R7 negated z");
      drive(32'h7F80_0000, 32'h0000_0001, 32'h4000_0000, 1, 0, 0, "R7 R12 subnormal product");
      // R8 zero product, nonzero z
      drive(32'h40E0_0000, 32'h0000_0000, 32'h40A0_0000, 0, 0, 0, "R8 z returned");
      drive(32'h40E0_0000, 32'h0000_0000, 32'h40A0_0000, 0, 1, 0, "R8 z negated");
      drive(32'h0000_0003, 32'h40A0_0000, 32'h8000_0000, 0, 0, 0, "R12 subnormal z kept");
      // R9 / R10 cancelling zeros
      drive(32'h8000_0000, 32'h8000_0000, 32'h40A0_0000, 0, 0, 0, "R9 -0 + -0");
      drive(32'h8000_0000, 32'h0000_0000, 32'h40A0_0000, 0, 0, 0, "R10 +0 + -0 nearest");
      drive(32'h8000_0000, 32'h0000_0000, 32'h40A0_0000, 0, 0, 1, "R10 +0 + -0 round down");
      drive(32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 0, 1, 1, "R10 negated addend round down");
      drive(32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1, 1, 1, "R9 both negated");
      // drain
      wait (exp_q.size() == 0);
      @(posedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule